// File: doc/BRIEF.md
# Tear-Free Counter Read Shadow

This block sits on the read path of a 32-bit free-running counter that is reached over a bus whose accesses may be 32 bits or 16 bits wide. A bus master that can only move 16 bits at a time needs two accesses to read the count. Between those two accesses the counter can carry from the low half into the high half, and the two halves would then come from different counts. The block prevents this with a 32-bit snapshot register. The snapshot takes the whole live count on every full-width read and on every read of the low half. A read of the high half is then answered from the snapshot and not from the live count.

Software gets a coherent value in either of two ways. It can issue one full-width read, or it can read the low half first and the high half second. The block decodes the access size from the byte enables. It produces one capture strobe for the snapshot and steers each 16-bit half of the registered read data. The counter itself and any clock-domain crossing in front of it are outside the block: the count arrives as a plain input.

Top module: `ctr_read_shadow`

## Requirements
- R1: After reset, `rspValid` is 0, `rspData` is 0 and the snapshot is 0. A high-half read issued first after reset therefore returns 0.
- R2: A full-width read has `reqValid`=1, `reqSel`=1, `reqWrite`=0 and `reqByteEn`=4'b1111. It produces `rspValid`=1 one cycle after it is accepted, with `rspData` equal to `liveCount` as sampled at the accepting clock edge.
- R3: A full-width read loads the whole snapshot with that same value. A later high-half read returns its upper 16 bits, whatever `liveCount` has become by then.
- R4: A low-half read (`reqByteEn`=4'b0011) returns `liveCount[15:0]` on `rspData[15:0]` and zeros on `rspData[31:16]`. It also loads the entire 32-bit snapshot from `liveCount`.
- R5: A high-half read (`reqByteEn`=4'b1100) returns snapshot bits 31:16 on `rspData[31:16]` and zeros on `rspData[15:0]`. It leaves the snapshot unchanged, so repeated high-half reads return the same value while the counter moves.
- R6: A write (`reqWrite`=1) to the counter register, of any width, gives no response and does not load the snapshot.
- R7: An access with `reqSel`=0 gives no response and does not load the snapshot.
- R8: A read with any byte-enable pattern other than 4'b1111, 4'b0011 or 4'b1100 gives no response and does not load the snapshot.
- R9: A low-half read followed in the very next cycle by a high-half read returns the two halves of a single count, even when `liveCount` changes between the two accesses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| liveCount | input | 32 | Live counter value, already stable in this clock domain |
| reqValid | input | 1 | Bus access present this cycle |
| reqWrite | input | 1 | 1 for a write, 0 for a read |
| reqSel | input | 1 | Access targets the counter register |
| reqByteEn | input | 4 | Byte enables that give the access size and half |
| rspValid | output | 1 | Read data valid, one cycle after an accepted read |
| rspData | output | 32 | Read data; unused lanes are zero |

## Verification
The case that is hardest to reach from the ports is a carry from the low half into the high half that happens between the two halves of a split read. The bench can only create it if the count changes exactly between two accesses that are one cycle apart. The bench drives `liveCount` itself. It issues the low-half read, changes the count to a value with a different upper half on the next falling edge, and issues the high-half read in that same cycle. It then confirms that the high half still matches the count seen by the low-half read.

// File: rtl/ctr_shadow_pkg.sv
package ctr_shadow_pkg;

  // Strobes passed from the access decoder to the datapath
  typedef struct packed {
    logic capture;   // load snapshot from the live count
    logic selFull;   // answer with the full live count
    logic selLow;    // answer with the live low half
    logic selHigh;   // answer with the snapshot high half
  } shadowStrobes_t;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_FULL = 2'd1,
    ACC_LOW  = 2'd2,
    ACC_HIGH = 2'd3
  } accessKind_e;

endpackage

// File: rtl/ctr_shadow_ctrl.sv
module ctr_shadow_ctrl
  import ctr_shadow_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic                reqSel,
  input  logic [DATA_W/8-1:0] reqByteEn,
  output shadowStrobes_t      strobes
);

  localparam int BE_W    = DATA_W / 8;
  localparam int HALF_BE = BE_W / 2;
  localparam logic [BE_W-1:0] FULL_MASK = {BE_W{1'b1}};
  localparam logic [BE_W-1:0] LOW_MASK  = {{HALF_BE{1'b0}}, {HALF_BE{1'b1}}};
  localparam logic [BE_W-1:0] HIGH_MASK = {{HALF_BE{1'b1}}, {HALF_BE{1'b0}}};

  accessKind_e accKind;
  logic        readHit;

  assign readHit = reqValid && reqSel && !reqWrite;

  always_comb begin
    accKind = ACC_NONE;
    if (readHit) begin
      if (reqByteEn == FULL_MASK)      accKind = ACC_FULL;
      else if (reqByteEn == LOW_MASK)  accKind = ACC_LOW;
      else if (reqByteEn == HIGH_MASK) accKind = ACC_HIGH;
    end
  end

  always_comb begin
    strobes         = '0;
    strobes.selFull = (accKind == ACC_FULL);
    strobes.selLow  = (accKind == ACC_LOW);
    strobes.selHigh = (accKind == ACC_HIGH);
    strobes.capture = (accKind == ACC_FULL) || (accKind == ACC_LOW);
  end

  AST_WRITE_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite) |-> !strobes.capture && !strobes.selHigh) else $error("write reached snapshot"); // R6

  AST_UNSEL_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    !reqSel |-> !strobes.capture && !strobes.selHigh) else $error("unselected access decoded"); // R7

  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.selFull, strobes.selLow, strobes.selHigh})) else $error("multiple kinds"); // R8

  AST_HIGH_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobes.selHigh |-> !strobes.capture) else $error("high read loads snapshot"); // R5

endmodule

// File: rtl/ctr_shadow_dp.sv
module ctr_shadow_dp
  import ctr_shadow_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] liveCount,
  input  shadowStrobes_t    strobes,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData
);

  localparam int HALF_W  = DATA_W / 2;
  localparam int N_HALVES = 2;

  logic [DATA_W-1:0] shadowQ;
  logic [DATA_W-1:0] nextData;
  logic              respond;

  assign respond = strobes.selFull | strobes.selLow | strobes.selHigh;

  // Per-half read data steering
  for (genvar h = 0; h < N_HALVES; h++) begin : g_half
    if (h == 0) begin : g_lowLane
      assign nextData[h*HALF_W +: HALF_W] =
        (strobes.selFull || strobes.selLow) ? liveCount[h*HALF_W +: HALF_W] : '0;
    end else begin : g_highLane
      assign nextData[h*HALF_W +: HALF_W] =
        strobes.selFull ? liveCount[h*HALF_W +: HALF_W] :
        strobes.selHigh ? shadowQ[h*HALF_W +: HALF_W]   : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowQ <= '0;
    end else if (strobes.capture) begin
      shadowQ <= liveCount;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= respond;
      rspData  <= nextData;
    end
  end

  AST_FULL_COHERENT: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.selFull) |-> rspValid && (rspData == shadowQ)) else $error("full read not coherent"); // R3

  AST_LOW_LANES: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.selLow) |-> (rspData[DATA_W-1:HALF_W] == '0) &&
                              (rspData[HALF_W-1:0] == shadowQ[HALF_W-1:0])) else $error("low lanes wrong"); // R4

  AST_HIGH_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.selHigh) |-> $stable(shadowQ) && (rspData[HALF_W-1:0] == '0) &&
                               (rspData[DATA_W-1:HALF_W] == shadowQ[DATA_W-1:HALF_W])) else $error("high read wrong"); // R5

  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rstN)
    !$past(respond) |-> !rspValid) else $error("spurious response"); // R8

  AST_HOLD_SNAPSHOT: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.capture) |-> $stable(shadowQ)) else $error("snapshot moved"); // R6

endmodule

// File: rtl/ctr_read_shadow.sv
module ctr_read_shadow
  import ctr_shadow_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [DATA_W-1:0]   liveCount,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic                reqSel,
  input  logic [DATA_W/8-1:0] reqByteEn,
  output logic                rspValid,
  output logic [DATA_W-1:0]   rspData
);

  shadowStrobes_t strobes;

  ctr_shadow_ctrl #(.DATA_W(DATA_W)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .reqSel    (reqSel),
    .reqByteEn (reqByteEn),
    .strobes   (strobes)
  );

  ctr_shadow_dp #(.DATA_W(DATA_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .liveCount (liveCount),
    .strobes   (strobes),
    .rspValid  (rspValid),
    .rspData   (rspData)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(!rstN) |-> !rspValid && (rspData == '0)) else $error("not quiet after reset"); // R1

endmodule

// File: tb/test_ctr_read_shadow.sv
module test_ctr_read_shadow;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] liveCount = '0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic        reqSel = 1'b0;
  logic [3:0]  reqByteEn = '0;
  logic        rspValid;
  logic [31:0] rspData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  ctr_read_shadow i_ctr_read_shadow (
    .clk       (clk),
    .rstN      (rstN),
    .liveCount (liveCount),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .reqSel    (reqSel),
    .reqByteEn (reqByteEn),
    .rspValid  (rspValid),
    .rspData   (rspData)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One access: drive on a falling edge, accepted on the rising edge, sampled on the next falling edge
  task automatic access(input logic sel, input logic wr, input logic [3:0] be,
                        output logic v, output logic [31:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqSel = sel; reqWrite = wr; reqByteEn = be;
    @(negedge clk);
    reqValid = 1'b0; reqSel = 1'b0; reqWrite = 1'b0; reqByteEn = '0;
    v = rspValid; d = rspData;
  endtask

  task automatic testReset();
    logic v; logic [31:0] d;
    chk("R1 rspValid", {31'd0, rspValid}, 32'd0);
    chk("R1 rspData", rspData, 32'd0);
    liveCount = 32'hDEAD_BEEF;
    access(1'b1, 1'b0, 4'b1100, v, d);
    chk("R1 high after reset", d, 32'h0000_0000);
  endtask

  task automatic testFull();
    logic v; logic [31:0] d;
    liveCount = 32'hA5A5_1234;
    access(1'b1, 1'b0, 4'b1111, v, d);
    chk("R2 valid", {31'd0, v}, 32'd1);
    chk("R2 data", d, 32'hA5A5_1234);
    liveCount = 32'h0F0F_9999;
    access(1'b1, 1'b0, 4'b1100, v, d);
    chk("R3 high from full snapshot", d, 32'hA5A5_0000);
  endtask

  task automatic testSplit();
    logic v; logic [31:0] d;
    liveCount = 32'h1111_2222;
    access(1'b1, 1'b0, 4'b0011, v, d);
    chk("R4 low valid", {31'd0, v}, 32'd1);
    chk("R4 low data", d, 32'h0000_2222);
    liveCount = 32'h3333_4444;
    access(1'b1, 1'b0, 4'b1100, v, d);
    chk("R4 snapshot high", d, 32'h1111_0000);
    liveCount = 32'h5555_6666;
    access(1'b1, 1'b0, 4'b1100, v, d);
    chk("R5 repeated high", d, 32'h1111_0000);
    chk("R5 valid", {31'd0, v}, 32'd1);
  endtask

  task automatic testIgnored();
    logic v; logic [31:0] d;
    liveCount = 32'h7777_8888;
    access(1'b1, 1'b1, 4'b1111, v, d);
    chk("R6 write no resp", {31'd0, v}, 32'd0);
    access(1'b1, 1'b1, 4'b0011, v, d);
    chk("R6 low write no resp", {31'd0, v}, 32'd0);
    access(1'b1, 1'b0, 4'b1100, v, d);
    chk("R6 snapshot kept", d, 32'h1111_0000);
    liveCount = 32'h9999_AAAA;
    access(1'b0, 1'b0, 4'b1111, v, d);
    chk("R7 unselected no resp", {31'd0, v}, 32'd0);
    access(1'b1, 1'b0, 4'b1100, v, d);
    chk("R7 snapshot kept", d, 32'h1111_0000);
    liveCount = 32'hBBBB_CCCC;
    access(1'b1, 1'b0, 4'b0001, v, d);
    chk("R8 be 0001 no resp", {31'd0, v}, 32'd0);
    access(1'b1, 1'b0, 4'b0110, v, d);
    chk("R8 be 0110 no resp", {31'd0, v}, 32'd0);
    access(1'b1, 1'b0, 4'b0111, v, d);
    chk("R8 be 0111 no resp", {31'd0, v}, 32'd0);
    access(1'b1, 1'b0, 4'b1100, v, d);
    chk("R8 snapshot kept", d, 32'h1111_0000);
  endtask

  task automatic testBackToBack();
    @(negedge clk);
    liveCount = 32'hBEEF_FFFF;
    reqValid = 1'b1; reqSel = 1'b1; reqWrite = 1'b0; reqByteEn = 4'b0011;
    @(negedge clk);
    chk("R9 low data", rspData, 32'h0000_FFFF);
    liveCount = 32'hBEF0_0000;  // carry into the upper half
    reqByteEn = 4'b1100;
    @(negedge clk);
    reqValid = 1'b0; reqSel = 1'b0; reqByteEn = '0;
    chk("R9 high coherent", rspData, 32'hBEEF_0000);
    chk("R9 valid", {31'd0, rspValid}, 32'd1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testReset();
    testFull();
    testSplit();
    testIgnored();
    testBackToBack();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule